// File: doc/BRIEF.md
# Compressed Instruction Format Classifier

This combinational block takes one 16-bit compressed instruction word and names its format. It raises exactly one bit of a one-hot format vector, or it raises an undefined flag when the encoding has no meaning. In parallel it pulls out every register index, immediate and branch displacement the word can carry. Each field is driven for every word, whatever the format, so the downstream execute stage picks only the ones its format uses.

The block also takes the four condition flags. For a conditional branch it evaluates the condition field against them and reports whether the branch is taken. Fetch, execution and the register file sit outside the block. The block has no clock. All outputs follow the inputs within the same cycle.

Top module: `hw16_insn_classifier`

## Requirements
- R1: When bits 15:13 are 000, a word with bits 12:11 = 11 is add/subtract (format index 1). Any other value is shift-by-immediate (index 0).
- R2: When bits 15:13 are 001, the word is an 8-bit-immediate operation (index 2). When bits 15:13 are 011, the word is an immediate-offset load/store (index 7).
- R3: When bits 15:13 are 010, bits 12:10 select the format. 000 gives register ALU (index 3), 001 gives high-register/exchange (index 4), 01x gives PC-relative load (index 5), and 1xx gives register-offset load/store (index 6).
- R4: When bits 15:13 are 100, bit 12 set gives SP-relative load/store (index 9). Bit 12 clear gives halfword load/store (index 8).
- R5: When bits 15:13 are 101 and bit 12 is clear, the word is an address add (index 10). When bit 12 is set, bits 10:9 select the format: 00 gives stack adjust (index 11), 10 gives push/pop (index 12), and 01 or 11 are undefined.
- R6: When bits 15:13 are 110 and bit 12 is clear, the word is a multiple load/store (index 13). When bit 12 is set, the condition field in bits 11:8 selects the format: 1111 gives software interrupt (index 15), 1110 is undefined, and any other value gives conditional branch (index 14).
- R7: When bits 15:13 are 111, bits 12:11 select the format: 00 gives unconditional branch (index 16), 10 gives long-branch high part (index 17), 11 gives long-branch low part (index 18), and 01 is undefined.
- R8: fmt_o has exactly one bit set when undef_o is low, and no bit set when undef_o is high.
- R9: The low register fields and immediates come from fixed bit positions. rd_o is bits 2:0, rs_o is bits 5:3, ro_o is bits 8:6, rb_o is bits 10:8, imm8_o is bits 7:0, and off5_o is bits 10:6.
- R10: hi_rd_o is bit 7 placed above bits 2:0. hi_rs_o is bits 6:3.
- R11: For a conditional branch, br_ofs_o is bits 7:0 taken as a signed value and multiplied by 2.
- R12: For an unconditional branch, br_ofs_o is bits 10:0 shifted left by one and sign-extended from bit 11.
- R13: For a long-branch high part, br_ofs_o is bits 10:0 sign-extended from bit 10 and multiplied by 4096. For a long-branch low part, it is bits 10:0 multiplied by 2, with no sign extension. For every other format, and for undefined words, br_ofs_o is zero.
- R14: With flags_i ordered N, Z, C, V from bit 3 down to bit 0, br_taken_o is high only for a conditional branch. Condition codes 0 to D mean, in order: Z, !Z, C, !C, N, !N, V, !V, C&!Z, !C|Z, N==V, N!=V, !Z&(N==V), and Z|(N!=V).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 16 | Instruction word |
| flags_i | input | 4 | Condition flags N,Z,C,V (bit 3 to bit 0) |
| fmt_o | output | 19 | One-hot format vector |
| undef_o | output | 1 | Encoding is undefined |
| rd_o | output | 3 | Low register field, bits 2:0 |
| rs_o | output | 3 | Low register field, bits 5:3 |
| ro_o | output | 3 | Low register field, bits 8:6 |
| rb_o | output | 3 | Low register field, bits 10:8 |
| hi_rd_o | output | 4 | High-register destination index |
| hi_rs_o | output | 4 | High-register source index |
| imm8_o | output | 8 | 8-bit immediate |
| off5_o | output | 5 | 5-bit offset |
| br_ofs_o | output | DATA_W | Branch displacement for the decoded format |
| br_taken_o | output | 1 | Conditional branch is taken |

## Verification
The bench sweeps all 65,536 instruction words and uses the low nibble of each word as the flag value. Together with the condition field, this covers every pair of condition code and flag setting. It targets the gaps in the decode tree: the two undefined stack-group codes, bits 12:11 = 01 in the branch group, and condition 1110. A decoder that missed any of these would either raise a format bit alongside undef_o or report no format with undef_o low. It also checks the sign boundaries of the three displacement formats. A wrong extension bit would turn the most negative offsets into large positive ones, or would sign-extend the low part of a long branch.

// File: rtl/hw16_dec_pkg.sv
package hw16_dec_pkg;
  localparam int FMT_N = 19;
  localparam int F_SHIFT_IMM = 0;
  localparam int F_ADD_SUB   = 1;
  localparam int F_IMM8_OP   = 2;
  localparam int F_ALU_REG   = 3;
  localparam int F_HIREG     = 4;
  localparam int F_PC_LOAD   = 5;
  localparam int F_REG_OFS   = 6;
  localparam int F_IMM_OFS   = 7;
  localparam int F_HALF_LS   = 8;
  localparam int F_SP_LS     = 9;
  localparam int F_ADDR_ADD  = 10;
  localparam int F_SP_ADJ    = 11;
  localparam int F_PUSH_POP  = 12;
  localparam int F_MULTI_LS  = 13;
  localparam int F_COND_BR   = 14;
  localparam int F_SWI       = 15;
  localparam int F_UNC_BR    = 16;
  localparam int F_LONG_HI   = 17;
  localparam int F_LONG_LO   = 18;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  function automatic logic cond_true(input logic [3:0] cc, input flags_t f);
    logic r;
    case (cc)
      4'h0: r = f.z;
      4'h1: r = !f.z;
      4'h2: r = f.c;
      4'h3: r = !f.c;
      4'h4: r = f.n;
      4'h5: r = !f.n;
      4'h6: r = f.v;
      4'h7: r = !f.v;
      4'h8: r = f.c && !f.z;
      4'h9: r = !f.c || f.z;
      4'hA: r = (f.n == f.v);
      4'hB: r = (f.n != f.v);
      4'hC: r = !f.z && (f.n == f.v);
      4'hD: r = f.z || (f.n != f.v);
      default: r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/hw16_class_tree.sv
module hw16_class_tree
  import hw16_dec_pkg::*;
(
  input  logic [15:0]      insn_i,
  output logic [FMT_N-1:0] fmt_o,
  output logic             undef_o
);
  always_comb begin
    fmt_o   = '0;
    undef_o = 1'b0;
    case (insn_i[15:13])
      3'd0: begin
        if (insn_i[12:11] == 2'b11) fmt_o[F_ADD_SUB] = 1'b1;
        else                        fmt_o[F_SHIFT_IMM] = 1'b1;
      end
      3'd1: fmt_o[F_IMM8_OP] = 1'b1;
      3'd2: begin
        casez (insn_i[12:10])
          3'b000:  fmt_o[F_ALU_REG] = 1'b1;
          3'b001:  fmt_o[F_HIREG]   = 1'b1;
          3'b01?:  fmt_o[F_PC_LOAD] = 1'b1;
          default: fmt_o[F_REG_OFS] = 1'b1;
        endcase
      end
      3'd3: fmt_o[F_IMM_OFS] = 1'b1;
      3'd4: begin
        if (insn_i[12]) fmt_o[F_SP_LS]   = 1'b1;
        else            fmt_o[F_HALF_LS] = 1'b1;
      end
      3'd5: begin
        if (!insn_i[12]) fmt_o[F_ADDR_ADD] = 1'b1;
        else begin
          case (insn_i[10:9])
            2'b00:   fmt_o[F_SP_ADJ]   = 1'b1;
            2'b10:   fmt_o[F_PUSH_POP] = 1'b1;
            default: undef_o = 1'b1;
          endcase
        end
      end
      3'd6: begin
        if (!insn_i[12])                 fmt_o[F_MULTI_LS] = 1'b1;
        else if (insn_i[11:8] == 4'hF)   fmt_o[F_SWI]      = 1'b1;
        else if (insn_i[11:8] == 4'hE)   undef_o = 1'b1;
        else                             fmt_o[F_COND_BR]  = 1'b1;
      end
      default: begin
        case (insn_i[12:11])
          2'b00:   fmt_o[F_UNC_BR]  = 1'b1;
          2'b10:   fmt_o[F_LONG_HI] = 1'b1;
          2'b11:   fmt_o[F_LONG_LO] = 1'b1;
          default: undef_o = 1'b1;
        endcase
      end
    endcase

    // R8
    one_format_chk: assert ($countones(fmt_o) == (undef_o ? 0 : 1));
    // R7
    branch_gap_chk: assert (!(insn_i[15:11] == 5'b11101) || (undef_o && fmt_o == '0));
    // R6
    cond_reserved_chk: assert (!(insn_i[15:8] == 8'hDE) || (undef_o && fmt_o == '0));
  end
endmodule

// File: rtl/hw16_field_extract.sv
module hw16_field_extract #(
  parameter int DATA_W = 32
) (
  input  logic [15:0]       insn_i,
  input  logic              is_cond_i,
  input  logic              is_unc_i,
  input  logic              is_lhi_i,
  input  logic              is_llo_i,
  output logic [2:0]        rd_o,
  output logic [2:0]        rs_o,
  output logic [2:0]        ro_o,
  output logic [2:0]        rb_o,
  output logic [3:0]        hi_rd_o,
  output logic [3:0]        hi_rs_o,
  output logic [7:0]        imm8_o,
  output logic [4:0]        off5_o,
  output logic [DATA_W-1:0] br_ofs_o
);
  localparam int LHI_SHIFT = 12;
  localparam int LHI_TOP   = 11 + LHI_SHIFT;

  function automatic logic [DATA_W-1:0] ofs_cond(input logic [7:0] i);
    return {{(DATA_W-9){i[7]}}, i, 1'b0};
  endfunction
  function automatic logic [DATA_W-1:0] ofs_unc(input logic [10:0] i);
    return {{(DATA_W-12){i[10]}}, i, 1'b0};
  endfunction
  function automatic logic [DATA_W-1:0] ofs_lhi(input logic [10:0] i);
    return {{(DATA_W-LHI_TOP){i[10]}}, i, {LHI_SHIFT{1'b0}}};
  endfunction
  function automatic logic [DATA_W-1:0] ofs_llo(input logic [10:0] i);
    return {{(DATA_W-12){1'b0}}, i, 1'b0};
  endfunction

  always_comb begin
    rd_o    = insn_i[2:0];
    rs_o    = insn_i[5:3];
    ro_o    = insn_i[8:6];
    rb_o    = insn_i[10:8];
    hi_rd_o = {insn_i[7], insn_i[2:0]};
    hi_rs_o = insn_i[6:3];
    imm8_o  = insn_i[7:0];
    off5_o  = insn_i[10:6];
    if (is_cond_i)     br_ofs_o = ofs_cond(insn_i[7:0]);
    else if (is_unc_i) br_ofs_o = ofs_unc(insn_i[10:0]);
    else if (is_lhi_i) br_ofs_o = ofs_lhi(insn_i[10:0]);
    else if (is_llo_i) br_ofs_o = ofs_llo(insn_i[10:0]);
    else               br_ofs_o = '0;

    // R13
    ofs_idle_chk: assert (is_cond_i || is_unc_i || is_lhi_i || is_llo_i || br_ofs_o == '0);
    // R11
    ofs_even_chk: assert (!(is_cond_i || is_unc_i) || !br_ofs_o[0]);
    // R10
    hi_low_share_chk: assert (hi_rd_o[2:0] == rd_o && hi_rs_o[2:0] == rs_o);
  end
endmodule

// File: rtl/hw16_cond_eval.sv
module hw16_cond_eval
  import hw16_dec_pkg::*;
(
  input  logic [3:0] cc_i,
  input  flags_t     flags_i,
  input  logic       sel_i,
  output logic       taken_o
);
  always_comb begin
    taken_o = sel_i && cond_true(cc_i, flags_i);
    // R14
    taken_sel_chk: assert (!taken_o || (sel_i && cc_i != 4'hE && cc_i != 4'hF));
    // R14
    eq_follow_chk: assert (!(sel_i && cc_i == 4'h0) || (taken_o == flags_i.z));
  end
endmodule

// File: rtl/hw16_insn_classifier.sv
module hw16_insn_classifier
  import hw16_dec_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [15:0]       insn_i,
  input  logic [3:0]        flags_i,
  output logic [18:0]       fmt_o,
  output logic              undef_o,
  output logic [2:0]        rd_o,
  output logic [2:0]        rs_o,
  output logic [2:0]        ro_o,
  output logic [2:0]        rb_o,
  output logic [3:0]        hi_rd_o,
  output logic [3:0]        hi_rs_o,
  output logic [7:0]        imm8_o,
  output logic [4:0]        off5_o,
  output logic [DATA_W-1:0] br_ofs_o,
  output logic              br_taken_o
);
  logic [FMT_N-1:0] fmt_w;
  logic             undef_w;
  flags_t           flags_w;

  assign flags_w = flags_i;

  hw16_class_tree u_tree (
    .insn_i  (insn_i),
    .fmt_o   (fmt_w),
    .undef_o (undef_w)
  );

  hw16_field_extract #(.DATA_W(DATA_W)) u_fields (
    .insn_i    (insn_i),
    .is_cond_i (fmt_w[F_COND_BR]),
    .is_unc_i  (fmt_w[F_UNC_BR]),
    .is_lhi_i  (fmt_w[F_LONG_HI]),
    .is_llo_i  (fmt_w[F_LONG_LO]),
    .rd_o      (rd_o),
    .rs_o      (rs_o),
    .ro_o      (ro_o),
    .rb_o      (rb_o),
    .hi_rd_o   (hi_rd_o),
    .hi_rs_o   (hi_rs_o),
    .imm8_o    (imm8_o),
    .off5_o    (off5_o),
    .br_ofs_o  (br_ofs_o)
  );

  hw16_cond_eval u_cond (
    .cc_i    (insn_i[11:8]),
    .flags_i (flags_w),
    .sel_i   (fmt_w[F_COND_BR]),
    .taken_o (br_taken_o)
  );

  assign fmt_o   = fmt_w;
  assign undef_o = undef_w;
endmodule

// File: tb/test_hw16_insn_classifier.sv
module test_hw16_insn_classifier;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] insn = 16'h0000;
  logic [3:0]  flags = 4'h0;
  logic [18:0] fmt;
  logic        undef;
  logic [2:0]  rd, rs, ro, rb;
  logic [3:0]  hi_rd, hi_rs;
  logic [7:0]  imm8;
  logic [4:0]  off5;
  logic [31:0] br_ofs;
  logic        taken;
  int          n_chk = 0;
  int          n_fail = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  hw16_insn_classifier i_hw16_insn_classifier (
    .insn_i(insn), .flags_i(flags), .fmt_o(fmt), .undef_o(undef),
    .rd_o(rd), .rs_o(rs), .ro_o(ro), .rb_o(rb), .hi_rd_o(hi_rd), .hi_rs_o(hi_rs),
    .imm8_o(imm8), .off5_o(off5), .br_ofs_o(br_ofs), .br_taken_o(taken)
  );

  function automatic int exp_index(input logic [15:0] w);
    casez (w)
      16'b00011???????????: return 1;
      16'b000?????????????: return 0;
      16'b001?????????????: return 2;
      16'b010000??????????: return 3;
      16'b010001??????????: return 4;
      16'b01001???????????: return 5;
      16'b0101????????????: return 6;
      16'b011?????????????: return 7;
      16'b1000????????????: return 8;
      16'b1001????????????: return 9;
      16'b1010????????????: return 10;
      16'b1011?00?????????: return 11;
      16'b1011?10?????????: return 12;
      16'b1100????????????: return 13;
      16'b11011111????????: return 15;
      16'b11011110????????: return -1;
      16'b1101????????????: return 14;
      16'b11100???????????: return 16;
      16'b11110???????????: return 17;
      16'b11111???????????: return 18;
      default:              return -1;
    endcase
  endfunction

  function automatic string req_of(input int k);
    if (k <= 1) return "R1";
    if (k == 2 || k == 7) return "R2";
    if (k <= 6) return "R3";
    if (k <= 9) return "R4";
    if (k <= 12) return "R5";
    if (k <= 15) return "R6";
    return "R7";
  endfunction

  function automatic int exp_ofs(input logic [15:0] w, input int k);
    int i11;
    i11 = int'(w[10:0]);
    if (k == 14) return (int'(w[7:0]) >= 128 ? int'(w[7:0]) - 256 : int'(w[7:0])) * 2;
    if (k == 16) return (i11 >= 1024 ? i11 - 2048 : i11) * 2;
    if (k == 17) return (i11 >= 1024 ? i11 - 2048 : i11) * 4096;
    if (k == 18) return i11 * 2;
    return 0;
  endfunction

  function automatic logic exp_taken(input logic [15:0] w, input logic [3:0] f, input int k);
    logic n, z, c, v, base;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    if (k != 14) return 1'b0;
    case (w[11:9])
      3'd0: base = z;
      3'd1: base = c;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = c & ~z;
      3'd5: base = ~(n ^ v);
      default: base = ~z & ~(n ^ v);
    endcase
    return base ^ w[8];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s insn=%h actual=%0h expected=%0h", req, what, insn, act, exp);
    end
  endtask

  task automatic check_word();
    int k;
    logic [18:0] efmt;
    k = exp_index(insn);
    efmt = (k < 0) ? 19'd0 : (19'd1 << k);
    // R8 and format requirements R1..R7
    check(fmt == efmt && undef == (k < 0), (k < 0) ? "R8" : req_of(k), "fmt",
          {fmt, undef}, {efmt, k < 0});
    // R9
    check(rd == insn[2:0] && rs == insn[5:3] && ro == insn[8:6] && rb == insn[10:8] &&
          imm8 == insn[7:0] && off5 == insn[10:6], "R9", "low fields",
          {rd, rs, ro, rb}, {insn[2:0], insn[5:3], insn[8:6], insn[10:8]});
    // R10
    check(int'(hi_rd) == int'(insn[7]) * 8 + int'(insn[2:0]) &&
          int'(hi_rs) == int'(insn[15:0] >> 3) % 16, "R10", "high fields",
          {hi_rd, hi_rs}, {insn[7], insn[2:0], insn[6:3]});
    // R11 R12 R13
    check($signed(br_ofs) == exp_ofs(insn, k),
          (k == 14) ? "R11" : (k == 16) ? "R12" : "R13", "br_ofs",
          longint'($signed(br_ofs)), longint'(exp_ofs(insn, k)));
    // R14
    check(taken == exp_taken(insn, flags, k), "R14", "taken",
          taken, exp_taken(insn, flags, k));
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset-state word 0000 is shift-by-immediate
    check(fmt == 19'd1 && !undef && br_ofs == 0 && !taken, "R1", "reset word",
          fmt, 19'd1);
    for (int w = 0; w < 65536; w++) begin
      @(posedge clk);
      insn  <= 16'(w);
      flags <= 4'(w);
      @(negedge clk);
      check_word();
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        #(8 * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule